// File: doc/BRIEF.md
# Speculative Load Poison Checker

This block looks at a speculative load in the cycle before it goes to memory and decides whether it may run. It receives the base register number, an optional displacement register number or a signed immediate, the destination register number, a size code and an integer/float select. It reads the two source values through a two-port register-file read interface and forms the effective address. It then checks whether the address and the destination register pair are aligned for the requested size.

The block never traps. A misalignment is recorded instead as a poison bit on the destination register, in one of two 64-bit poison banks (integer and float). A load whose source registers carry poison is suppressed, and its destination inherits the poison. When the fault log is switched on, each checked load fills the lowest free log slot with a status record and its effective address. Software returns a slot to the free pool through a release mask.

All results are registered, so the verdict appears one clock after the request.

Top module: `spec_load_checker`

## Requirements
- R1: The effective address is the base register value plus the displacement register value when `req_disp_use` is 1. When `req_disp_use` is 0 it is the base value plus `req_imm`, wrapping modulo 2^32. The result is reported on `rsp_ea`.
- R2: Size codes are 0 (unsigned byte), 1 (signed byte), 2 (unsigned halfword), 3 (signed halfword) and 4 (word). Byte sizes never report an address fault. Halfwords report one when address bit 0 is 1. Words report one when address bits 1:0 are nonzero.
- R3: Size code 5 (doubleword) reports an address fault when address bits 2:0 are nonzero. It reports a register fault when the destination number is odd.
- R4: Size code 6 (quadword) reports an address fault when address bits 3:0 are nonzero. It reports a register fault when destination bits 1:0 are nonzero.
- R5: On an address or register fault, the destination's poison bit is set and `rsp_proceed` is 1. The bank used is `poison_fp` when `req_is_float` is 1 and `poison_int` otherwise. Bit n of a bank belongs to register n. The other bank is untouched.
- R6: With no fault, the destination's poison bit is set and `rsp_proceed` is 0 when the base register is poisoned. The same holds when the displacement register is poisoned and `req_disp_use` is 1. Source bits are read from the bank chosen by `req_is_float`. A displacement register that is not used has no effect.
- R7: With no fault and no poisoned source, the destination's poison bit is cleared and `rsp_proceed` is 1.
- R8: Logging is on only when `log_ctrl_valid` and `log_ctrl_enable` are both 1. When it is on, a legal request fills the lowest-numbered free slot and reports that slot on `rsp_log_wr`/`rsp_log_idx`. The slot holds valid=1, address-valid=1, the destination, the size code, the slot's own number, the float select and the effective address.
- R9: A logged slot holds reg-misaligned=1 only when the register fault fired and mem-misaligned=1 only when the address fault fired. Otherwise both are 0.
- R10: With logging on and no free slot, `rsp_log_full` is 1 and `rsp_proceed` is 0. No slot is written and neither poison bank changes.
- R11: Size code 7 sets `rsp_illegal_size` and gives `rsp_proceed`=0. No fault is reported, no poison bit changes and no slot is written.
- R12: After reset both poison banks are zero, every slot is free and `rsp_valid` is 0. Each request's result appears on the response outputs one clock later, and `rsp_valid` stays high for exactly one cycle.
- R13: A 1 in `log_release` bit i frees slot i, and `log_busy` bit i falls on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load is presented this cycle |
| req_base_idx | input | 6 | Base register number |
| req_disp_use | input | 1 | 1: add displacement register, 0: add immediate |
| req_disp_idx | input | 6 | Displacement register number |
| req_imm | input | 32 | Signed immediate displacement |
| req_target_idx | input | 6 | Destination register number |
| req_size | input | 3 | Access size code |
| req_is_float | input | 1 | Destination is a float register |
| log_ctrl_valid | input | 1 | Log control word is valid |
| log_ctrl_enable | input | 1 | Log enable bit |
| rf_a_idx | output | 6 | Register-file read port A address (base) |
| rf_a_data | input | 32 | Register-file read port A data |
| rf_b_idx | output | 6 | Register-file read port B address (displacement) |
| rf_b_data | input | 32 | Register-file read port B data |
| log_release | input | 4 | Per-slot free request |
| log_rd_sel | input | 2 | Slot shown on the log read port |
| rsp_valid | output | 1 | Result of last cycle's request is present |
| rsp_proceed | output | 1 | Load may be performed |
| rsp_addr_fault | output | 1 | Address misaligned for the size |
| rsp_reg_fault | output | 1 | Destination register pair misaligned |
| rsp_illegal_size | output | 1 | Undefined size code |
| rsp_log_full | output | 1 | Logging on but no free slot |
| rsp_ea | output | 32 | Effective address |
| rsp_log_wr | output | 1 | A log slot was written |
| rsp_log_idx | output | 2 | Slot written |
| poison_int | output | 64 | Integer poison bank |
| poison_fp | output | 64 | Float poison bank |
| log_busy | output | 4 | Occupied slots |
| log_rd_valid | output | 1 | Selected slot valid bit |
| log_rd_addr_valid | output | 1 | Selected slot address-valid bit |
| log_rd_dest | output | 6 | Selected slot destination |
| log_rd_size | output | 3 | Selected slot size code |
| log_rd_num | output | 2 | Selected slot own number |
| log_rd_fp | output | 1 | Selected slot float bit |
| log_rd_reg_mis | output | 1 | Selected slot register-misaligned code |
| log_rd_mem_mis | output | 1 | Selected slot memory-misaligned code |
| log_rd_addr | output | 32 | Selected slot effective address |

## Verification
The properties assume that the register-file data answers the read addresses within the same cycle. They also assume that a slot being written is never released in that same cycle, and that the request inputs are stable over the clock edge. The stimulus meets these by modelling the register file as a combinational array. It drives every request and release on the falling edge, and it issues releases only in cycles that carry no request, so a slot's write and its release never coincide.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam int REG_IDX_W = 6;

    typedef enum logic [2:0] {
        SZ_UBYTE = 3'd0,
        SZ_SBYTE = 3'd1,
        SZ_UHALF = 3'd2,
        SZ_SHALF = 3'd3,
        SZ_WORD  = 3'd4,
        SZ_DWORD = 3'd5,
        SZ_QWORD = 3'd6,
        SZ_BAD   = 3'd7
    } size_e;

endpackage

// File: rtl/slc_ea_unit.sv
module slc_ea_unit #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              disp_use,
    input  logic [IDX_W-1:0]  disp_idx,
    input  logic [DATA_W-1:0] imm,
    output logic [IDX_W-1:0]  rd_a_idx,
    input  logic [DATA_W-1:0] rd_a_data,
    output logic [IDX_W-1:0]  rd_b_idx,
    input  logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] ea
);
    logic [DATA_W-1:0] offset;

    assign rd_a_idx = base_idx;
    assign rd_b_idx = disp_idx;

    always_comb begin
        offset = disp_use ? rd_b_data : imm;
        ea     = rd_a_data + offset;
    end
endmodule

// File: rtl/slc_align_unit.sv
module slc_align_unit #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] ea,
    input  logic [IDX_W-1:0]  target_idx,
    output logic              addr_fault,
    output logic              reg_fault,
    output logic              illegal
);
    import slc_pkg::*;

    logic [3:0] addr_mask;
    logic [1:0] reg_mask;

    always_comb begin
        addr_mask = 4'h0;
        reg_mask  = 2'b00;
        illegal   = 1'b0;
        case (size_e'(size))
            SZ_UBYTE, SZ_SBYTE: addr_mask = 4'h0;
            SZ_UHALF, SZ_SHALF: addr_mask = 4'h1;
            SZ_WORD:            addr_mask = 4'h3;
            SZ_DWORD: begin
                addr_mask = 4'h7;
                reg_mask  = 2'b01;
            end
            SZ_QWORD: begin
                addr_mask = 4'hF;
                reg_mask  = 2'b11;
            end
            default:            illegal = 1'b1;
        endcase
        addr_fault = |(ea[3:0] & addr_mask);
        reg_fault  = |(target_idx[1:0] & reg_mask);
    end
endmodule

// File: rtl/slc_free_pick.sv
module slc_free_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant[g]  = ~busy[g] & ~seen[g];
        assign seen[g+1] = seen[g] | ~busy[g];
    end

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/spec_load_checker.sv
module spec_load_checker #(
    parameter int DATA_W  = 32,
    parameter int NUM_LOG = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic [slc_pkg::REG_IDX_W-1:0]      req_base_idx,
    input  logic                               req_disp_use,
    input  logic [slc_pkg::REG_IDX_W-1:0]      req_disp_idx,
    input  logic [DATA_W-1:0]                  req_imm,
    input  logic [slc_pkg::REG_IDX_W-1:0]      req_target_idx,
    input  logic [2:0]                         req_size,
    input  logic                               req_is_float,
    input  logic                               log_ctrl_valid,
    input  logic                               log_ctrl_enable,
    output logic [slc_pkg::REG_IDX_W-1:0]      rf_a_idx,
    input  logic [DATA_W-1:0]                  rf_a_data,
    output logic [slc_pkg::REG_IDX_W-1:0]      rf_b_idx,
    input  logic [DATA_W-1:0]                  rf_b_data,
    input  logic [NUM_LOG-1:0]                 log_release,
    input  logic [$clog2(NUM_LOG)-1:0]         log_rd_sel,
    output logic                               rsp_valid,
    output logic                               rsp_proceed,
    output logic                               rsp_addr_fault,
    output logic                               rsp_reg_fault,
    output logic                               rsp_illegal_size,
    output logic                               rsp_log_full,
    output logic [DATA_W-1:0]                  rsp_ea,
    output logic                               rsp_log_wr,
    output logic [$clog2(NUM_LOG)-1:0]         rsp_log_idx,
    output logic [(2**slc_pkg::REG_IDX_W)-1:0] poison_int,
    output logic [(2**slc_pkg::REG_IDX_W)-1:0] poison_fp,
    output logic [NUM_LOG-1:0]                 log_busy,
    output logic                               log_rd_valid,
    output logic                               log_rd_addr_valid,
    output logic [slc_pkg::REG_IDX_W-1:0]      log_rd_dest,
    output logic [2:0]                         log_rd_size,
    output logic [$clog2(NUM_LOG)-1:0]         log_rd_num,
    output logic                               log_rd_fp,
    output logic                               log_rd_reg_mis,
    output logic                               log_rd_mem_mis,
    output logic [DATA_W-1:0]                  log_rd_addr
);
    import slc_pkg::*;

    localparam int IDX_W     = REG_IDX_W;
    localparam int NUM_REGS  = 2 ** IDX_W;
    localparam int LOG_IDX_W = $clog2(NUM_LOG);

    typedef struct packed {
        logic                 valid;
        logic                 addr_valid;
        logic [IDX_W-1:0]     dest;
        logic [2:0]           size;
        logic [LOG_IDX_W-1:0] num;
        logic                 fp;
        logic                 reg_mis;
        logic                 mem_mis;
    } slot_t;

    typedef struct packed {
        logic [NUM_REGS-1:0]               pint;
        logic [NUM_REGS-1:0]               pfp;
        slot_t [NUM_LOG-1:0]               slot;
        logic [NUM_LOG-1:0][DATA_W-1:0]    addr;
        logic                              r_valid;
        logic                              r_proceed;
        logic                              r_af;
        logic                              r_rf;
        logic                              r_ill;
        logic                              r_full;
        logic                              r_logwr;
        logic [LOG_IDX_W-1:0]              r_logidx;
        logic [DATA_W-1:0]                 r_ea;
        logic [IDX_W-1:0]                  r_tgt;
        logic                              r_fp;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0]    ea;
    logic                 addr_fault, reg_fault, size_bad;
    logic [NUM_LOG-1:0]   busy_now;
    logic                 free_found;
    logic [LOG_IDX_W-1:0] free_idx;

    slc_ea_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ea (
        .base_idx  (req_base_idx),
        .disp_use  (req_disp_use),
        .disp_idx  (req_disp_idx),
        .imm       (req_imm),
        .rd_a_idx  (rf_a_idx),
        .rd_a_data (rf_a_data),
        .rd_b_idx  (rf_b_idx),
        .rd_b_data (rf_b_data),
        .ea        (ea)
    );

    slc_align_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_align (
        .size       (req_size),
        .ea         (ea),
        .target_idx (req_target_idx),
        .addr_fault (addr_fault),
        .reg_fault  (reg_fault),
        .illegal    (size_bad)
    );

    for (genvar g = 0; g < NUM_LOG; g++) begin : g_busy
        assign busy_now[g] = st_q.slot[g].valid;
    end

    slc_free_pick #(.N(NUM_LOG), .IDX_W(LOG_IDX_W)) u_pick (
        .busy  (busy_now),
        .found (free_found),
        .idx   (free_idx)
    );

    logic [NUM_REGS-1:0] bank;
    logic                src_poison;
    logic                log_on;
    logic                full;
    logic                accept;

    always_comb begin
        st_d           = st_q;
        st_d.r_valid   = 1'b0;
        st_d.r_proceed = 1'b0;
        st_d.r_af      = 1'b0;
        st_d.r_rf      = 1'b0;
        st_d.r_ill     = 1'b0;
        st_d.r_full    = 1'b0;
        st_d.r_logwr   = 1'b0;

        for (int i = 0; i < NUM_LOG; i++) begin
            if (log_release[i]) begin
                st_d.slot[i].valid      = 1'b0;
                st_d.slot[i].addr_valid = 1'b0;
            end
        end

        bank       = req_is_float ? st_q.pfp : st_q.pint;
        src_poison = bank[req_base_idx] | (req_disp_use & bank[req_disp_idx]);
        log_on     = log_ctrl_valid & log_ctrl_enable;
        full       = log_on & ~free_found;
        accept     = ~size_bad & ~full;

        if (req_valid) begin
            st_d.r_valid  = 1'b1;
            st_d.r_af     = addr_fault;
            st_d.r_rf     = reg_fault;
            st_d.r_ill    = size_bad;
            st_d.r_full   = full;
            st_d.r_ea     = ea;
            st_d.r_tgt    = req_target_idx;
            st_d.r_fp     = req_is_float;

            if (accept) begin
                if (addr_fault || reg_fault) begin
                    bank[req_target_idx] = 1'b1;
                    st_d.r_proceed       = 1'b1;
                end else if (src_poison) begin
                    bank[req_target_idx] = 1'b1;
                    st_d.r_proceed       = 1'b0;
                end else begin
                    bank[req_target_idx] = 1'b0;
                    st_d.r_proceed       = 1'b1;
                end

                if (req_is_float) st_d.pfp  = bank;
                else              st_d.pint = bank;

                if (log_on) begin
                    st_d.slot[free_idx].valid      = 1'b1;
                    st_d.slot[free_idx].addr_valid = 1'b1;
                    st_d.slot[free_idx].dest       = req_target_idx;
                    st_d.slot[free_idx].size       = req_size;
                    st_d.slot[free_idx].num        = free_idx;
                    st_d.slot[free_idx].fp         = req_is_float;
                    st_d.slot[free_idx].reg_mis    = reg_fault;
                    st_d.slot[free_idx].mem_mis    = addr_fault;
                    st_d.addr[free_idx]            = ea;
                    st_d.r_logwr                   = 1'b1;
                    st_d.r_logidx                  = free_idx;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid         = st_q.r_valid;
    assign rsp_proceed       = st_q.r_proceed;
    assign rsp_addr_fault    = st_q.r_af;
    assign rsp_reg_fault     = st_q.r_rf;
    assign rsp_illegal_size  = st_q.r_ill;
    assign rsp_log_full      = st_q.r_full;
    assign rsp_ea            = st_q.r_ea;
    assign rsp_log_wr        = st_q.r_logwr;
    assign rsp_log_idx       = st_q.r_logidx;
    assign poison_int        = st_q.pint;
    assign poison_fp         = st_q.pfp;
    assign log_busy          = busy_now;
    assign log_rd_valid      = st_q.slot[log_rd_sel].valid;
    assign log_rd_addr_valid = st_q.slot[log_rd_sel].addr_valid;
    assign log_rd_dest       = st_q.slot[log_rd_sel].dest;
    assign log_rd_size       = st_q.slot[log_rd_sel].size;
    assign log_rd_num        = st_q.slot[log_rd_sel].num;
    assign log_rd_fp         = st_q.slot[log_rd_sel].fp;
    assign log_rd_reg_mis    = st_q.slot[log_rd_sel].reg_mis;
    assign log_rd_mem_mis    = st_q.slot[log_rd_sel].mem_mis;
    assign log_rd_addr       = st_q.addr[log_rd_sel];

    logic tgt_flag_q;
    assign tgt_flag_q = st_q.r_fp ? st_q.pfp[st_q.r_tgt] : st_q.pint[st_q.r_tgt];

    assert_byte_no_addr_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_size == SZ_UBYTE || req_size == SZ_SBYTE) |=> !rsp_addr_fault);

    assert_dword_odd_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size == SZ_DWORD && req_target_idx[0] |=> rsp_reg_fault);

    assert_quad_target_mis_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size == SZ_QWORD && (req_target_idx[1:0] != 2'b00) |=> rsp_reg_fault);

    assert_fault_poisons_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_addr_fault || rsp_reg_fault) && !rsp_illegal_size && !rsp_log_full
        |-> tgt_flag_q && rsp_proceed);

    assert_suppress_poisons_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_proceed && !rsp_illegal_size && !rsp_log_full |-> tgt_flag_q);

    assert_clean_clears_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_proceed && !rsp_addr_fault && !rsp_reg_fault |-> !tgt_flag_q);

    assert_written_slot_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_log_wr |-> log_busy[rsp_log_idx]);

    assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_log_full |-> !rsp_log_wr && !rsp_proceed);

    assert_illegal_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_size == SZ_BAD |=> rsp_illegal_size && !rsp_proceed && !rsp_log_wr);

    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_release_frees_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && (log_release != '0) |=> ((log_busy & $past(log_release)) == '0));

endmodule

// File: tb/spec_load_checker_tb.sv
`timescale 1ns/1ps
module spec_load_checker_tb;

    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_base_idx = '0;
    logic        req_disp_use = 1'b0;
    logic [5:0]  req_disp_idx = '0;
    logic [31:0] req_imm = '0;
    logic [5:0]  req_target_idx = '0;
    logic [2:0]  req_size = '0;
    logic        req_is_float = 1'b0;
    logic        log_ctrl_valid = 1'b0;
    logic        log_ctrl_enable = 1'b0;
    logic [5:0]  rf_a_idx, rf_b_idx;
    logic [31:0] rf_a_data, rf_b_data;
    logic [NL-1:0] log_release = '0;
    logic [1:0]  log_rd_sel = '0;
    logic        rsp_valid, rsp_proceed, rsp_addr_fault, rsp_reg_fault;
    logic        rsp_illegal_size, rsp_log_full, rsp_log_wr;
    logic [31:0] rsp_ea;
    logic [1:0]  rsp_log_idx;
    logic [63:0] poison_int, poison_fp;
    logic [NL-1:0] log_busy;
    logic        log_rd_valid, log_rd_addr_valid, log_rd_fp, log_rd_reg_mis, log_rd_mem_mis;
    logic [5:0]  log_rd_dest;
    logic [2:0]  log_rd_size;
    logic [1:0]  log_rd_num;
    logic [31:0] log_rd_addr;

    logic [31:0] rf_mem [64];
    assign rf_a_data = rf_mem[rf_a_idx];
    assign rf_b_data = rf_mem[rf_b_idx];

    always #2 clk = ~clk;

    spec_load_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_base_idx(req_base_idx), .req_disp_use(req_disp_use),
        .req_disp_idx(req_disp_idx), .req_imm(req_imm),
        .req_target_idx(req_target_idx), .req_size(req_size),
        .req_is_float(req_is_float), .log_ctrl_valid(log_ctrl_valid),
        .log_ctrl_enable(log_ctrl_enable), .rf_a_idx(rf_a_idx),
        .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .log_release(log_release), .log_rd_sel(log_rd_sel),
        .rsp_valid(rsp_valid), .rsp_proceed(rsp_proceed),
        .rsp_addr_fault(rsp_addr_fault), .rsp_reg_fault(rsp_reg_fault),
        .rsp_illegal_size(rsp_illegal_size), .rsp_log_full(rsp_log_full),
        .rsp_ea(rsp_ea), .rsp_log_wr(rsp_log_wr), .rsp_log_idx(rsp_log_idx),
        .poison_int(poison_int), .poison_fp(poison_fp), .log_busy(log_busy),
        .log_rd_valid(log_rd_valid), .log_rd_addr_valid(log_rd_addr_valid),
        .log_rd_dest(log_rd_dest), .log_rd_size(log_rd_size),
        .log_rd_num(log_rd_num), .log_rd_fp(log_rd_fp),
        .log_rd_reg_mis(log_rd_reg_mis), .log_rd_mem_mis(log_rd_mem_mis),
        .log_rd_addr(log_rd_addr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [63:0] m_pint = '0, m_pfp = '0;
    logic [NL-1:0] m_busy = '0;
    logic [5:0]  m_dest [NL];
    logic [2:0]  m_size [NL];
    logic        m_fp [NL], m_rm [NL], m_mm [NL];
    logic [31:0] m_addr [NL];

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input string tag, input logic [5:0] base, input logic use_d,
                         input logic [5:0] disp, input logic [31:0] imm, input logic [5:0] tgt,
                         input logic [2:0] size, input logic fp, input logic logon);
        logic [31:0] ea;
        logic [3:0]  am;
        logic [1:0]  rm;
        logic        ill, af, rfl, srcp, found, full, ok, proceed, logwr;
        logic [1:0]  fidx;
        logic [63:0] bank;
        ea = rf_mem[base] + (use_d ? rf_mem[disp] : imm);
        am = 4'h0; rm = 2'b00; ill = 1'b0;
        case (size)
            3'd0, 3'd1: am = 4'h0;
            3'd2, 3'd3: am = 4'h1;
            3'd4: am = 4'h3;
            3'd5: begin am = 4'h7; rm = 2'b01; end
            3'd6: begin am = 4'hF; rm = 2'b11; end
            default: ill = 1'b1;
        endcase
        af   = |(ea[3:0] & am);
        rfl  = |(tgt[1:0] & rm);
        bank = fp ? m_pfp : m_pint;
        srcp = bank[base] | (use_d & bank[disp]);
        found = 1'b0; fidx = '0;
        for (int i = NL - 1; i >= 0; i--) if (!m_busy[i]) begin found = 1'b1; fidx = 2'(i); end
        full    = logon & ~found;
        ok      = ~ill & ~full;
        proceed = ok & (af | rfl | ~srcp);
        logwr   = ok & logon;
        if (ok) begin
            bank[tgt] = (af | rfl | srcp);
            if (fp) m_pfp = bank; else m_pint = bank;
            if (logon) begin
                m_busy[fidx] = 1'b1; m_dest[fidx] = tgt; m_size[fidx] = size;
                m_fp[fidx] = fp; m_rm[fidx] = rfl; m_mm[fidx] = af; m_addr[fidx] = ea;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_base_idx = base; req_disp_use = use_d; req_disp_idx = disp;
        req_imm = imm; req_target_idx = tgt; req_size = size; req_is_float = fp;
        log_ctrl_valid = logon; log_ctrl_enable = logon;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'(1'b1));
        chk(tag, "rsp_ea", 64'(rsp_ea), 64'(ea));
        chk(tag, "rsp_proceed", 64'(rsp_proceed), 64'(proceed));
        chk(tag, "rsp_addr_fault", 64'(rsp_addr_fault), 64'(af));
        chk(tag, "rsp_reg_fault", 64'(rsp_reg_fault), 64'(rfl));
        chk(tag, "rsp_illegal_size", 64'(rsp_illegal_size), 64'(ill));
        chk(tag, "rsp_log_full", 64'(rsp_log_full), 64'(full));
        chk(tag, "rsp_log_wr", 64'(rsp_log_wr), 64'(logwr));
        if (logwr) chk(tag, "rsp_log_idx", 64'(rsp_log_idx), 64'(fidx));
        chk(tag, "poison_int", poison_int, m_pint);
        chk(tag, "poison_fp", poison_fp, m_pfp);
        chk(tag, "log_busy", 64'(log_busy), 64'(m_busy));
    endtask

    task automatic check_slot(input string tag, input logic [1:0] s);
        @(negedge clk);
        log_rd_sel = s;
        #1;
        chk(tag, "slot valid", 64'(log_rd_valid), 64'(1'b1));
        chk(tag, "slot addr_valid", 64'(log_rd_addr_valid), 64'(1'b1));
        chk(tag, "slot dest", 64'(log_rd_dest), 64'(m_dest[s]));
        chk(tag, "slot size", 64'(log_rd_size), 64'(m_size[s]));
        chk(tag, "slot num", 64'(log_rd_num), 64'(s));
        chk(tag, "slot fp", 64'(log_rd_fp), 64'(m_fp[s]));
        chk(tag, "slot reg_mis", 64'(log_rd_reg_mis), 64'(m_rm[s]));
        chk(tag, "slot mem_mis", 64'(log_rd_mem_mis), 64'(m_mm[s]));
        chk(tag, "slot addr", 64'(log_rd_addr), 64'(m_addr[s]));
    endtask

    task automatic release_slots(input logic [NL-1:0] mask);
        @(negedge clk);
        log_release = mask;
        @(posedge clk); #1;
        log_release = '0;
        m_busy = m_busy & ~mask;
        chk("R13", "log_busy after release", 64'(log_busy), 64'(m_busy));
    endtask

    task automatic t_reset;
        chk("R12", "rsp_valid at reset", 64'(rsp_valid), 64'(1'b0));
        chk("R12", "poison_int at reset", poison_int, 64'd0);
        chk("R12", "poison_fp at reset", poison_fp, 64'd0);
        chk("R12", "log_busy at reset", 64'(log_busy), 64'd0);
    endtask

    task automatic t_ea;
        issue("R1", 6'd3, 1'b1, 6'd5, 32'd0, 6'd10, 3'd4, 1'b0, 1'b0);
        issue("R1", 6'd3, 1'b0, 6'd5, 32'hFFFF_FFF0, 6'd10, 3'd4, 1'b0, 1'b0);
        @(posedge clk); #1;
        chk("R12", "rsp_valid one-cycle pulse", 64'(rsp_valid), 64'(1'b0));
    endtask

    task automatic t_small;
        rf_mem[20] = 32'h0000_2001;
        issue("R2", 6'd20, 1'b0, 6'd0, 32'd0, 6'd30, 3'd1, 1'b0, 1'b0);
        issue("R2", 6'd20, 1'b0, 6'd0, 32'd0, 6'd30, 3'd0, 1'b0, 1'b0);
        issue("R2", 6'd20, 1'b0, 6'd0, 32'd0, 6'd31, 3'd2, 1'b0, 1'b0);
        issue("R2", 6'd20, 1'b0, 6'd0, 32'd1, 6'd31, 3'd3, 1'b0, 1'b0);
        issue("R2", 6'd20, 1'b0, 6'd0, 32'd1, 6'd30, 3'd4, 1'b0, 1'b0);
        issue("R2", 6'd20, 1'b0, 6'd0, 32'd3, 6'd30, 3'd4, 1'b0, 1'b0);
    endtask

    task automatic t_dword;
        issue("R3", 6'd20, 1'b0, 6'd0, 32'd7, 6'd32, 3'd5, 1'b0, 1'b0);
        issue("R3", 6'd20, 1'b0, 6'd0, 32'd7, 6'd33, 3'd5, 1'b0, 1'b0);
        issue("R3", 6'd20, 1'b0, 6'd0, 32'd3, 6'd34, 3'd5, 1'b0, 1'b0);
    endtask

    task automatic t_quad;
        issue("R4", 6'd20, 1'b0, 6'd0, 32'd15, 6'd36, 3'd6, 1'b0, 1'b0);
        issue("R4", 6'd20, 1'b0, 6'd0, 32'd15, 6'd38, 3'd6, 1'b0, 1'b0);
        issue("R4", 6'd20, 1'b0, 6'd0, 32'd15, 6'd41, 3'd6, 1'b0, 1'b0);
        issue("R4", 6'd20, 1'b0, 6'd0, 32'd7, 6'd40, 3'd6, 1'b0, 1'b0);
    endtask

    task automatic t_bank;
        issue("R5", 6'd1, 1'b0, 6'd0, 32'd0, 6'd45, 3'd5, 1'b1, 1'b0);
        chk("R5", "int bank bit 45 untouched", 64'(poison_int[45]), 64'(1'b0));
        issue("R5", 6'd1, 1'b0, 6'd0, 32'd1, 6'd50, 3'd2, 1'b0, 1'b0);
    endtask

    task automatic t_src;
        issue("R6", 6'd50, 1'b0, 6'd0, 32'd0, 6'd51, 3'd4, 1'b0, 1'b0);
        issue("R6", 6'd1, 1'b1, 6'd50, 32'd0, 6'd52, 3'd4, 1'b0, 1'b0);
        issue("R6", 6'd1, 1'b0, 6'd50, 32'd0, 6'd53, 3'd4, 1'b0, 1'b0);
        issue("R6", 6'd50, 1'b0, 6'd0, 32'd0, 6'd54, 3'd4, 1'b1, 1'b0);
    endtask

    task automatic t_clear;
        issue("R7", 6'd1, 1'b0, 6'd0, 32'd0, 6'd51, 3'd4, 1'b0, 1'b0);
        chk("R7", "bit 51 cleared", 64'(poison_int[51]), 64'(1'b0));
    endtask

    task automatic t_log;
        rf_mem[21] = 32'h0000_3005;
        log_ctrl_valid = 1'b1; log_ctrl_enable = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_base_idx = 6'd1; req_disp_use = 1'b0; req_imm = '0;
        req_target_idx = 6'd56; req_size = 3'd4; req_is_float = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R8", "enable bit clear gives no log write", 64'(rsp_log_wr), 64'(1'b0));
        chk("R8", "enable bit clear keeps slots free", 64'(log_busy), 64'(m_busy));
        issue("R9", 6'd21, 1'b0, 6'd0, 32'd0, 6'd57, 3'd5, 1'b0, 1'b1);
        issue("R8", 6'd1, 1'b0, 6'd0, 32'd0, 6'd44, 3'd6, 1'b1, 1'b1);
        check_slot("R9", 2'd0);
        check_slot("R8", 2'd1);
        release_slots(4'b0001);
        issue("R8", 6'd1, 1'b0, 6'd0, 32'd4, 6'd58, 3'd4, 1'b0, 1'b1);
        check_slot("R8", 2'd0);
    endtask

    task automatic t_full;
        issue("R8", 6'd1, 1'b0, 6'd0, 32'd0, 6'd59, 3'd4, 1'b0, 1'b1);
        issue("R8", 6'd1, 1'b0, 6'd0, 32'd0, 6'd59, 3'd4, 1'b0, 1'b1);
        issue("R10", 6'd21, 1'b0, 6'd0, 32'd0, 6'd60, 3'd4, 1'b0, 1'b1);
        chk("R10", "bit 60 unchanged", 64'(poison_int[60]), 64'(1'b0));
        issue("R10", 6'd50, 1'b0, 6'd0, 32'd0, 6'd59, 3'd4, 1'b0, 1'b0);
        release_slots(4'b1111);
    endtask

    task automatic t_illegal;
        issue("R11", 6'd50, 1'b0, 6'd0, 32'd1, 6'd61, 3'd7, 1'b0, 1'b1);
        issue("R11", 6'd1, 1'b0, 6'd0, 32'd0, 6'd59, 3'd7, 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) rf_mem[i] = 32'h1000 + 32'(i) * 32'h40;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_ea();
        t_small();
        t_dword();
        t_quad();
        t_bank();
        t_src();
        t_clear();
        t_log();
        t_full();
        t_illegal();
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule